// File: doc/BRIEF.md
# Doorbell-Driven Transfer Ring Consumer

This block is the device-side consumer for one host-to-device work ring. The host prepares ring slots in its own memory and then writes a doorbell that carries the new write pointer. The block keeps its own read pointer and compares it with the latched write pointer to see whether work is pending. It fetches each pending slot through a request/response memory read port and shows the slot's contents (buffer address, length, chain bit) on a valid/ready output. Once the element is accepted, the read pointer advances and wraps at the ring depth.

A descriptor is a run of chained elements and ends with the first element whose chain bit is clear. When that last element is handed off, the block sends a one-cycle completion pulse toward the event producer. The pulse carries the read pointer value that follows the descriptor.

The host sets the ring base and an initial pointer before the ring is used. Doorbells that arrive while a fetch is in flight are merged into the latched write pointer. A doorbell that would shrink the pending work is treated as a ring overrun: it is rejected and flagged.

Top module: `ring_consumer`

## Requirements
- R1: After reset the ring is empty (`empty`=1, `full`=0), and `req_valid`, `out_valid`, `cpl_valid` and `db_err` are all 0.
- R2: A `cfg_load` pulse sets both the read and the write pointer to `cfg_ptr`, which leaves the ring empty. It takes priority over a doorbell in the same cycle.
- R3: `empty` is 1 exactly when the read pointer equals the write pointer. `full` is 1 exactly when the write pointer plus one, modulo DEPTH, equals the read pointer. Both flags are never 1 together.
- R4: No memory request is made until a doorbell moves the write pointer away from the read pointer. Slots are then fetched in ring order, and the request address is `cfg_base + 16*slot`.
- R5: While `out_valid` is 1 and `out_ready` is 0, the output element stays valid and unchanged. Each accepted element equals the contents of the slot at the read pointer.
- R6: The read pointer advances by one per accepted element and wraps from DEPTH-1 to 0.
- R7: `cpl_valid` pulses for one cycle, the cycle after an element with chain bit 0 is accepted, and `cpl_ptr` then holds the read pointer after that element. An accepted element with chain bit 1 produces no completion.
- R8: Doorbells received while the block is busy are merged: the latest valid write pointer is kept, and every element it covers is delivered.
- R9: A doorbell is rejected when `(db_wp - rp) mod DEPTH` is smaller than the current pending count `(wp - rp) mod DEPTH`. A rejected doorbell leaves the write pointer unchanged and raises `db_err` for one cycle, one cycle later.
- R10: At most one memory request is outstanding. While `req_ready` is 0, `req_valid` and `req_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load both pointers from cfg_ptr |
| cfg_ptr | input | PW | Initial pointer value |
| cfg_base | input | AW | Ring base address in host memory |
| db_valid | input | 1 | Doorbell write strobe |
| db_wp | input | PW | Write pointer carried by the doorbell |
| db_err | output | 1 | Rejected-doorbell pulse |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory read request accepted |
| req_addr | output | AW | Address of the slot being read |
| rsp_valid | input | 1 | Read response valid |
| rsp_addr | input | AW | Slot buffer address field |
| rsp_len | input | LW | Slot length field |
| rsp_chain | input | 1 | Slot chain bit (1 = more elements follow) |
| out_valid | output | 1 | Element valid |
| out_ready | input | 1 | Element accepted by consumer |
| out_addr | output | AW | Element buffer address |
| out_len | output | LW | Element length |
| out_chain | output | 1 | Element chain bit |
| cpl_valid | output | 1 | Descriptor completion pulse |
| cpl_ptr | output | PW | Read pointer after the completed descriptor |
| empty | output | 1 | Ring empty flag |
| full | output | 1 | Ring full flag |

## Verification
Two things can happen in the same cycle: a doorbell write, and the hand-off of an element that moves the read pointer. In that cycle the overrun judgment must use the read pointer as it was before the move, and the write pointer update must still land. The bench provokes this by sending random doorbells while `out_ready` toggles at random. It judges the outcome by checking that every slot the host published is delivered exactly once and in order, and that every completion pointer matches its descriptor. A directed case holds the output stalled on a full ring and sends an overrun doorbell, then checks that the error fires and that the full flag does not change.

// File: rtl/ring_consumer.sv
module ring_consumer #(
  parameter int DEPTH   = 16,
  parameter int AW      = 64,
  parameter int LW      = 16,
  parameter int ESZ_LOG = 4,
  localparam int PW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [PW-1:0] cfg_ptr,
  input  logic [AW-1:0] cfg_base,
  input  logic          db_valid,
  input  logic [PW-1:0] db_wp,
  output logic          db_err,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_addr,
  input  logic [LW-1:0] rsp_len,
  input  logic          rsp_chain,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [LW-1:0] out_len,
  output logic          out_chain,
  output logic          cpl_valid,
  output logic [PW-1:0] cpl_ptr,
  output logic          empty,
  output logic          full
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_OUT} st_t;

  st_t           st;
  logic [PW-1:0] rp, wp;
  logic [PW-1:0] pend, new_pend, rp_inc;
  logic          db_bad, take;

  assign rp_inc    = rp + PW'(1);
  assign pend      = wp - rp;
  assign new_pend  = db_wp - rp;
  assign db_bad    = db_valid && (new_pend < pend);
  assign take      = out_valid && out_ready;
  assign req_valid = (st == S_REQ);
  assign out_valid = (st == S_OUT);
  assign req_addr  = cfg_base + (AW'(rp) << ESZ_LOG);
  assign empty     = (rp == wp);
  assign full      = ((wp + PW'(1)) == rp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rp        <= '0;
      wp        <= '0;
      db_err    <= 1'b0;
      cpl_valid <= 1'b0;
      cpl_ptr   <= '0;
      out_addr  <= '0;
      out_len   <= '0;
      out_chain <= 1'b0;
    end else begin
      db_err    <= db_bad && !cfg_load;
      cpl_valid <= take && !out_chain;
      if (take && !out_chain) cpl_ptr <= rp_inc;
      if (cfg_load) begin
        rp <= cfg_ptr;
        wp <= cfg_ptr;
        st <= S_IDLE;
      end else begin
        if (db_valid && !db_bad) wp <= db_wp;
        case (st)
          S_IDLE: if (rp != wp) st <= S_REQ;
          S_REQ:  if (req_ready) st <= S_WAIT;
          S_WAIT: if (rsp_valid) begin
            out_addr  <= rsp_addr;
            out_len   <= rsp_len;
            out_chain <= rsp_chain;
            st        <= S_OUT;
          end
          S_OUT:  if (out_ready) begin
            rp <= rp_inc;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ring_consumer_chk.sv
module ring_consumer_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 64,
  parameter int LW    = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          db_valid,
  input logic          db_err,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [LW-1:0] out_len,
  input logic          out_chain,
  input logic          cpl_valid,
  input logic          empty,
  input logic          full
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(empty && full)); // R3
  AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> !empty); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_chain)); // R5
  AST_CPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cpl_valid |=> !cpl_valid); // R7
  AST_CPL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_chain |=> !cpl_valid); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(db_err) |-> $past(db_valid)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && out_valid)); // R10
endmodule

bind ring_consumer ring_consumer_chk #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_err(db_err),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_len(out_len), .out_chain(out_chain), .cpl_valid(cpl_valid),
  .empty(empty), .full(full)
);

// File: tb/test_ring_consumer.sv
module test_ring_consumer;
  localparam int DEPTH = 16;
  localparam int PW = 4;
  localparam logic [63:0] BASE = 64'h0000_0000_1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [PW-1:0] cfg_ptr = '0;
  logic [63:0] cfg_base = BASE;
  logic db_valid = 1'b0;
  logic [PW-1:0] db_wp = '0;
  logic db_err, req_valid, req_ready, rsp_valid, rsp_chain;
  logic [63:0] req_addr, rsp_addr, out_addr;
  logic [15:0] rsp_len, out_len;
  logic out_valid, out_ready, out_chain, cpl_valid, empty, full;
  logic [PW-1:0] cpl_ptr;

  always #2.5 clk = ~clk;

  ring_consumer i_ring_consumer (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ptr(cfg_ptr), .cfg_base(cfg_base),
    .db_valid(db_valid), .db_wp(db_wp), .db_err(db_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_len(rsp_len), .rsp_chain(rsp_chain),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_len(out_len),
    .out_chain(out_chain), .cpl_valid(cpl_valid), .cpl_ptr(cpl_ptr), .empty(empty), .full(full)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_addr [DEPTH];
  logic [15:0] m_len [DEPTH];
  logic        m_chain [DEPTH];
  logic [PW-1:0] exp_rp = '0, exp_req = '0, wp_model = '0;
  logic [PW-1:0] cplq [$];
  int req_count = 0, cpl_seen = 0;
  bit hold_out = 0;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return p + PW'(1);
  endfunction

  function automatic logic [63:0] slot_addr(logic [PW-1:0] p);
    return BASE + (64'(p) << 4);
  endfunction

  task automatic chk(bit ok, string r, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // memory model and output/completion monitor
  initial begin
    bit have = 0;
    int dly = 0;
    logic [PW-1:0] slot = '0;
    req_ready = 0; rsp_valid = 0; rsp_addr = '0; rsp_len = '0; rsp_chain = 0; out_ready = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        have = 0; rsp_valid = 0; req_ready = 0; out_ready = 0;
        continue;
      end
      if (cpl_valid) begin
        cpl_seen++;
        if (cplq.size() == 0) chk(0, "R7 unexpected completion", cpl_ptr, 0);
        else begin
          logic [PW-1:0] e;
          e = cplq.pop_front();
          chk(cpl_ptr == e, "R7 completion pointer", cpl_ptr, e);
        end
      end
      rsp_valid = 0;
      if (have) begin
        if (dly == 0) begin
          rsp_valid = 1; rsp_addr = m_addr[slot]; rsp_len = m_len[slot];
          rsp_chain = m_chain[slot]; have = 0;
        end else dly--;
      end
      req_ready = ($urandom % 2) == 0;
      if (req_valid && req_ready && !have) begin
        chk(req_addr == slot_addr(exp_req), "R4 request address", req_addr, slot_addr(exp_req));
        slot = exp_req;
        exp_req = nxt(exp_req);
        req_count++;
        have = 1;
        dly = $urandom % 4;
      end else if (req_valid && have) req_ready = 0;
      out_ready = hold_out ? 1'b0 : (($urandom % 4) != 0);
      if (out_valid && out_ready) begin
        chk(out_addr == m_addr[exp_rp] && out_len == m_len[exp_rp] && out_chain == m_chain[exp_rp],
            "R5 element content", out_addr, m_addr[exp_rp]);
        if (!m_chain[exp_rp]) cplq.push_back(nxt(exp_rp));
        exp_rp = nxt(exp_rp);
      end
    end
  end

  task automatic put(logic [PW-1:0] s, bit ch);
    m_addr[s] = {$urandom, $urandom};
    m_len[s] = 16'($urandom);
    m_chain[s] = ch;
  endtask

  task automatic ring(logic [PW-1:0] w);
    db_valid = 1; db_wp = w;
    @(negedge clk);
    db_valid = 0;
  endtask

  task automatic drain(string r);
    int n = 0;
    while ((exp_rp != wp_model || out_valid || req_valid) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    chk(exp_rp == wp_model, r, exp_rp, wp_model);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) put(PW'(i), 0);
    repeat (3) @(negedge clk);
    chk(empty == 1 && full == 0, "R1 reset flags", {empty, full}, 2'b10);
    chk(!req_valid && !out_valid && !cpl_valid && !db_err, "R1 reset outputs",
        {req_valid, out_valid, cpl_valid, db_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: load pointers near the wrap point; doorbell in same cycle loses
    cfg_load = 1; cfg_ptr = 4'd14; db_valid = 1; db_wp = 4'd3;
    exp_rp = 4'd14; exp_req = 4'd14; wp_model = 4'd14;
    @(negedge clk);
    cfg_load = 0; db_valid = 0;
    chk(empty == 1, "R2 load leaves ring empty", empty, 1);
    repeat (6) @(negedge clk);
    chk(req_count == 0, "R4 no fetch without doorbell", req_count, 0);

    // R6/R7: descriptors crossing the wrap
    put(4'd14, 1); put(4'd15, 0); put(4'd0, 1); put(4'd1, 0);
    wp_model = 4'd2;
    ring(4'd2);
    drain("R6 wrap drain");
    chk(cpl_seen == 2, "R7 one completion per descriptor", cpl_seen, 2);
    chk(empty == 1, "R3 empty after drain", empty, 1);

    // R8: merged doorbells while output stalled; R3 full; R9 rejected doorbell
    hold_out = 1;
    for (int i = 2; i < 17; i++) put(PW'(i), (i % 3) == 0);
    put(4'd0, 0);
    ring(4'd4);
    ring(4'd9);
    repeat (8) @(negedge clk);
    chk(full == 0 && empty == 0, "R3 partial flags", {empty, full}, 0);
    ring(4'd1);
    chk(full == 1, "R3 full flag", full, 1);
    wp_model = 4'd1;
    ring(4'd5);
    chk(db_err == 1, "R9 overrun flagged", db_err, 1);
    @(negedge clk);
    chk(db_err == 0, "R9 error is one pulse", db_err, 0);
    chk(full == 1, "R9 write pointer unchanged", full, 1);
    hold_out = 0;
    drain("R8 merged doorbells drained");
    chk(cplq.size() == 0, "R7 completions all seen", cplq.size(), 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int freev;
      freev = DEPTH - 1 - int'(PW'(wp_model - exp_rp));
      k = (freev > 0) ? ($urandom % (freev + 1)) : 0;
      for (int j = 0; j < k; j++) begin
        put(wp_model, ($urandom % 3) == 0);
        wp_model = nxt(wp_model);
        if (($urandom % 4) == 0) ring(wp_model);
      end
      if (k > 0) ring(wp_model);
      repeat ($urandom % 8) @(negedge clk);
    end
    m_chain[PW'(wp_model - PW'(1))] = 0;
    drain("R8 random traffic drained");
    repeat (4) @(negedge clk);
    chk(cplq.size() == 0, "R7 random completions", cplq.size(), 0);
    chk(!out_valid && !req_valid, "R4 idle after drain", {out_valid, req_valid}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule